// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block is the reset manager of a small 8-bit microcontroller core. It merges six reset causes into one core reset and one reset output for external peripherals. The causes are power-on, undervoltage, a manual pin, a watchdog trip, a reset requested by software, and a program fetch outside the on-chip program memory. Analog voltage detection and the watchdog counter sit outside the block, and only their trip signals come in.

Causes fall into two groups. Delayed causes (power-on and undervoltage) keep the core in reset for a long stretch after the condition ends. Fast causes (manual pin, watchdog, software request, illegal fetch) give a short fixed pulse. An illegal fetch either resets the core directly or, in interrupt mode, sends a falling-edge request so that firmware can react first. A sticky cause register records which sources have fired. A separate flag tells a cold start from a warm one. The power-on input is the block's own asynchronous reset. The undervoltage and manual inputs pass through two-flop synchronizers.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `core_rst_n` and `periph_rst_n` are low, `rst_cause` is 6'b000001 and `last_cold` is 1. After `por_n` rises, `core_rst_n` goes high at the STRETCH-th rising clock edge (default 1024).
- R2: `uv_trip` is synchronized by two flops. The core reset asserts at the third edge after `uv_trip` rises. It is released at the (2+STRETCH)-th edge after `uv_trip` falls.
- R3: `mrst_n` low is synchronized by two flops. The core reset asserts at the third edge after the pin falls. It is released at the (2+FAST_LEN)-th edge after the pin rises (default FAST_LEN 16).
- R4: A `wdt_trip` sampled high at an edge drops `core_rst_n` after that edge for exactly FAST_LEN cycles. A fast cause never shortens a longer reset already running.
- R5: `periph_rst_n` is low only during power-on resets and watchdog-started resets. It is released at the same edge as `core_rst_n`. Undervoltage, manual, software and illegal-fetch resets leave it high.
- R6: A rising `sw_req` seen at edge E0 while the core is out of reset asserts the core reset at edge E0+SW_DELAY (default 8). The reset lasts FAST_LEN cycles.
- R7: A fetch is illegal when `fetch_valid` is high, `ext_prog_en` is low, 0 < `pmem_kb` < 64 and `fetch_addr[15:10]` >= `pmem_kb`. In every other case no illegal fetch is reported.
- R8: With `iaf_direct` low, an illegal fetch drives `iaf_irq_n` low for the cycle after the sampling edge. It causes no reset and sets no cause bit.
- R9: With `iaf_direct` high, an illegal fetch starts a FAST_LEN-cycle core reset from the sampling edge and sets cause bit 5.
- R10: `rst_cause` bits are sticky: bit 0 power-on, 1 undervoltage, 2 manual, 3 watchdog, 4 software, 5 illegal fetch. A 1 on `cause_w1c` clears the matching bit at the next edge. A set in the same cycle wins over the clear.
- R11: `last_cold` is set by power-on and cleared by any warm cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| uv_trip | input | 1 | Undervoltage trip, asynchronous, active high |
| mrst_n | input | 1 | Manual reset pin, asynchronous, active low |
| wdt_trip | input | 1 | Watchdog overflow pulse, synchronous |
| sw_req | input | 1 | Software reset control bit from the core |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| ext_prog_en | input | 1 | External program memory in use (disables detection) |
| pmem_kb | input | 7 | On-chip program memory size in KB |
| iaf_direct | input | 1 | 1: illegal fetch resets directly, 0: interrupt first |
| cause_w1c | input | 6 | Write-one-to-clear strobes for the cause bits |
| core_rst_n | output | 1 | Core reset, active low |
| periph_rst_n | output | 1 | Peripheral reset output, active low |
| iaf_irq_n | output | 1 | Illegal-fetch interrupt request, falling edge |
| rst_cause | output | 6 | Sticky reset cause bits |
| last_cold | output | 1 | Last reset was cold |

## Verification
Watchdog, software and direct illegal-fetch resets change `core_rst_n` right after the sampling edge, or SW_DELAY edges later for software. They end exactly FAST_LEN edges later. The synchronized inputs add two edges on assertion and two on release. The bench counts rising edges from each stimulus and samples on the falling edge. It checks both the last cycle before each expected transition and the cycle at it. It also sweeps every memory size from 0 to 64 against addresses on both sides of each limit, with and without external memory, and computes the expected interrupt outcome arithmetically.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
  localparam int NSRC    = 6;
  localparam int IDX_POR = 0;
  localparam int IDX_UV  = 1;
  localparam int IDX_MAN = 2;
  localparam int IDX_WDG = 3;
  localparam int IDX_SW  = 4;
  localparam int IDX_IAF = 5;
  typedef logic [NSRC-1:0] cause_t;
endpackage

// File: rtl/rstc_sync.sv
`timescale 1ns/1ps
module rstc_sync #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d[g];
        s2_q <= s1_q;
      end
    end
    assign q[g] = s2_q;
  end
endmodule

// File: rtl/rstc_fetch_guard.sv
`timescale 1ns/1ps
module rstc_fetch_guard #(
  parameter int PAGE_W = 6,
  parameter int SIZE_W = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              fetch_valid,
  input  logic [PAGE_W-1:0] fetch_page,
  input  logic              ext_prog_en,
  input  logic [SIZE_W-1:0] size_kb,
  input  logic              direct_mode,
  output logic              rst_hit,
  output logic              irq_n
);
  localparam logic [SIZE_W-1:0] FULL_V = SIZE_W'(1 << PAGE_W);

  logic armed, illegal, irq_q, irq_d;

  always_comb begin
    armed   = !ext_prog_en && (size_kb != '0) && (size_kb < FULL_V);
    illegal = fetch_valid && armed && (SIZE_W'(fetch_page) >= size_kb);
    rst_hit = illegal && direct_mode;
    irq_d   = !(illegal && !direct_mode);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) irq_q <= 1'b1;
    else         irq_q <= irq_d;
  end
  assign irq_n = irq_q;

  a_r7_ext_mem_off: assert property (@(posedge clk) disable iff (!arst_n)
    (fetch_valid && ext_prog_en) |=> irq_n);
  a_r8_irq_needs_fetch: assert property (@(posedge clk) disable iff (!arst_n)
    (!irq_n && $past(arst_n)) |-> $past(fetch_valid && !direct_mode));
endmodule

// File: rtl/rstc_swreq.sv
`timescale 1ns/1ps
module rstc_swreq #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  input  logic hold,
  output logic fire
);
  localparam int DW = $clog2(DELAY + 1);
  localparam logic [DW-1:0] DELAY_V = DW'(DELAY);

  logic          req_q;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          rise;

  always_comb begin
    rise   = req && !req_q && !hold && (dcnt_q == '0);
    dcnt_d = dcnt_q;
    if (rise)                dcnt_d = DELAY_V;
    else if (dcnt_q != '0)   dcnt_d = dcnt_q - DW'(1);
    fire   = (dcnt_q == DW'(1));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      req_q  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      req_q  <= req;
      dcnt_q <= dcnt_d;
    end
  end

  a_r6_single_fire: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> !fire);
endmodule

// File: rtl/rstc_seq.sv
`timescale 1ns/1ps
module rstc_seq #(
  parameter int STRETCH  = 1024,
  parameter int FAST_LEN = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic dly_cond,
  input  logic fast_evt,
  input  logic wdg_evt,
  output logic core_rst_n,
  output logic periph_rst_n
);
  localparam int MAXV = (STRETCH > FAST_LEN) ? STRETCH : FAST_LEN;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] STR_V  = CW'(STRETCH);
  localparam logic [CW-1:0] FAST_V = CW'(FAST_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          per_q, per_d;
  logic          core_q, core_d;

  always_comb begin
    cnt_d = cnt_q;
    if (dly_cond)
      cnt_d = STR_V;
    else if (fast_evt)
      cnt_d = (cnt_q > FAST_V) ? cnt_q - CW'(1) : FAST_V;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
    core_d = (cnt_d == '0);
    per_d  = (per_q || wdg_evt) && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= STR_V;
      per_q  <= 1'b1;
      core_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      core_q <= core_d;
    end
  end

  assign core_rst_n   = core_q;
  assign periph_rst_n = !per_q;

  a_r2_delayed_hold: assert property (@(posedge clk) disable iff (!arst_n)
    dly_cond |=> !core_rst_n);
  a_r4_fast_assert: assert property (@(posedge clk) disable iff (!arst_n)
    fast_evt |=> !core_rst_n);
  a_r4_wdg_periph: assert property (@(posedge clk) disable iff (!arst_n)
    wdg_evt |=> !periph_rst_n);
  a_r5_periph_within_core: assert property (@(posedge clk) disable iff (!arst_n)
    !periph_rst_n |-> !core_rst_n);
endmodule

// File: rtl/rstc_cause.sv
`timescale 1ns/1ps
module rstc_cause
  import rstc_pkg::*;
(
  input  logic   clk,
  input  logic   arst_n,
  input  cause_t set,
  input  cause_t clr,
  output cause_t cause,
  output logic   last_cold
);
  cause_t cause_q, cause_d;
  logic   cold_q, cold_d;

  always_comb begin
    cause_d = (cause_q & ~clr) | set;
    cold_d  = (|set) ? 1'b0 : cold_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cause_q <= cause_t'(1) << IDX_POR;
      cold_q  <= 1'b1;
    end else begin
      cause_q <= cause_d;
      cold_q  <= cold_d;
    end
  end

  assign cause     = cause_q;
  assign last_cold = cold_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r10_sticky: assert property (@(posedge clk) disable iff (!arst_n)
      (cause[i] && !clr[i]) |=> cause[i]);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!arst_n)
      set[i] |=> cause[i]);
  end
  a_r11_warm_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (|set) |=> !last_cold);
endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor
  import rstc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int GRAN_LOG = 10,
  parameter int SIZE_W   = ADDR_W - GRAN_LOG + 1,
  parameter int STRETCH  = 1024,
  parameter int FAST_LEN = 16,
  parameter int SW_DELAY = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              uv_trip,
  input  logic              mrst_n,
  input  logic              wdt_trip,
  input  logic              sw_req,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ext_prog_en,
  input  logic [SIZE_W-1:0] pmem_kb,
  input  logic              iaf_direct,
  input  logic [NSRC-1:0]   cause_w1c,
  output logic              core_rst_n,
  output logic              periph_rst_n,
  output logic              iaf_irq_n,
  output logic [NSRC-1:0]   rst_cause,
  output logic              last_cold
);
  localparam int PAGE_W = ADDR_W - GRAN_LOG;

  logic [1:0] sync_q;
  logic       uv_s, man_s, sw_fire, iaf_rst, fast_evt;
  cause_t     set_v;
  logic       unused_low;

  assign unused_low = ^fetch_addr[GRAN_LOG-1:0];

  rstc_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk(clk), .arst_n(por_n), .d({uv_trip, !mrst_n}), .q(sync_q));
  assign uv_s  = sync_q[1];
  assign man_s = sync_q[0];

  rstc_fetch_guard #(.PAGE_W(PAGE_W), .SIZE_W(SIZE_W)) u_guard (
    .clk(clk), .arst_n(por_n), .fetch_valid(fetch_valid),
    .fetch_page(fetch_addr[ADDR_W-1:GRAN_LOG]), .ext_prog_en(ext_prog_en),
    .size_kb(pmem_kb), .direct_mode(iaf_direct),
    .rst_hit(iaf_rst), .irq_n(iaf_irq_n));

  rstc_swreq #(.DELAY(SW_DELAY)) u_swreq (
    .clk(clk), .arst_n(por_n), .req(sw_req), .hold(!core_rst_n), .fire(sw_fire));

  assign fast_evt = man_s || wdt_trip || sw_fire || iaf_rst;

  rstc_seq #(.STRETCH(STRETCH), .FAST_LEN(FAST_LEN)) u_seq (
    .clk(clk), .arst_n(por_n), .dly_cond(uv_s), .fast_evt(fast_evt),
    .wdg_evt(wdt_trip), .core_rst_n(core_rst_n), .periph_rst_n(periph_rst_n));

  always_comb begin
    set_v          = '0;
    set_v[IDX_UV]  = uv_s;
    set_v[IDX_MAN] = man_s;
    set_v[IDX_WDG] = wdt_trip;
    set_v[IDX_SW]  = sw_fire;
    set_v[IDX_IAF] = iaf_rst;
  end

  rstc_cause u_cause (
    .clk(clk), .arst_n(por_n), .set(set_v), .clr(cause_w1c),
    .cause(rst_cause), .last_cold(last_cold));
endmodule

// File: tb/rst_supervisor_bench.sv
`timescale 1ns/1ps
module rst_supervisor_bench;
  localparam int STR  = 1024;
  localparam int FAST = 16;
  localparam int SWD  = 8;

  logic clk = 1'b0;
  logic por_n, uv_trip, mrst_n, wdt_trip, sw_req, fetch_valid, ext_prog_en, iaf_direct;
  logic [15:0] fetch_addr;
  logic [6:0]  pmem_kb;
  logic [5:0]  cause_w1c, rst_cause;
  logic core_rst_n, periph_rst_n, iaf_irq_n, last_cold;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rst_supervisor u_rst_supervisor (
    .clk(clk), .por_n(por_n), .uv_trip(uv_trip), .mrst_n(mrst_n),
    .wdt_trip(wdt_trip), .sw_req(sw_req), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .ext_prog_en(ext_prog_en), .pmem_kb(pmem_kb),
    .iaf_direct(iaf_direct), .cause_w1c(cause_w1c), .core_rst_n(core_rst_n),
    .periph_rst_n(periph_rst_n), .iaf_irq_n(iaf_irq_n), .rst_cause(rst_cause),
    .last_cold(last_cold));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_causes();
    cause_w1c = 6'h3f;
    edges(1);
    cause_w1c = 6'h00;
    chk("R10 cleared", rst_cause, 0);
  endtask

  initial begin
    por_n = 1'b0; uv_trip = 1'b0; mrst_n = 1'b1; wdt_trip = 1'b0; sw_req = 1'b0;
    fetch_valid = 1'b0; fetch_addr = '0; ext_prog_en = 1'b0; pmem_kb = 7'd8;
    iaf_direct = 1'b0; cause_w1c = '0;
    edges(3);
    // R1 power-on state
    chk("R1 core during por", core_rst_n, 0);
    chk("R1 periph during por", periph_rst_n, 0);
    chk("R1 cause during por", rst_cause, 1);
    chk("R1 cold during por", last_cold, 1);
    por_n = 1'b1;
    edges(STR - 1);
    chk("R1 core before stretch end", core_rst_n, 0);
    chk("R5 periph in cold stretch", periph_rst_n, 0);
    edges(1);
    chk("R1 core released", core_rst_n, 1);
    chk("R5 periph released", periph_rst_n, 1);
    clear_causes();

    // R4 watchdog with simultaneous clear (R10 set wins)
    wdt_trip = 1'b1; cause_w1c = 6'b001000;
    edges(1);
    wdt_trip = 1'b0; cause_w1c = '0;
    chk("R4 core after wdt", core_rst_n, 0);
    chk("R4 periph after wdt", periph_rst_n, 0);
    chk("R10 wdt bit set wins", rst_cause, 6'b001000);
    chk("R11 warm after wdt", last_cold, 0);
    edges(FAST - 1);
    chk("R4 core still low", core_rst_n, 0);
    chk("R4 periph still low", periph_rst_n, 0);
    edges(1);
    chk("R4 core released", core_rst_n, 1);
    chk("R4 periph released", periph_rst_n, 1);
    clear_causes();

    // R3 manual pin
    mrst_n = 1'b0;
    edges(2);
    chk("R3 core before sync", core_rst_n, 1);
    edges(1);
    chk("R3 core asserted", core_rst_n, 0);
    chk("R5 periph on manual", periph_rst_n, 1);
    edges(2);
    mrst_n = 1'b1;
    edges(1 + FAST);
    chk("R3 core still low", core_rst_n, 0);
    edges(1);
    chk("R3 core released", core_rst_n, 1);
    chk("R10 manual bit", rst_cause, 6'b000100);
    clear_causes();

    // R2 undervoltage
    uv_trip = 1'b1;
    edges(2);
    chk("R2 core before sync", core_rst_n, 1);
    edges(1);
    chk("R2 core asserted", core_rst_n, 0);
    edges(2);
    uv_trip = 1'b0;
    edges(1 + STR);
    chk("R2 core still low", core_rst_n, 0);
    chk("R5 periph on undervoltage", periph_rst_n, 1);
    edges(1);
    chk("R2 core released", core_rst_n, 1);
    chk("R10 uv bit", rst_cause, 6'b000010);
    clear_causes();

    // R6 software request
    sw_req = 1'b1;
    edges(SWD);
    chk("R6 core before delay", core_rst_n, 1);
    edges(1);
    chk("R6 core asserted", core_rst_n, 0);
    chk("R5 periph on software", periph_rst_n, 1);
    sw_req = 1'b0;
    edges(FAST - 1);
    chk("R6 core still low", core_rst_n, 0);
    edges(1);
    chk("R6 core released", core_rst_n, 1);
    chk("R10 sw bit", rst_cause, 6'b010000);
    clear_causes();

    // R7 R8 sweep in interrupt mode
    iaf_direct = 1'b0;
    for (int ext = 0; ext < 2; ext++) begin
      for (int sz = 0; sz <= 64; sz++) begin
        int lim;
        int al [4];
        lim = sz * 1024;
        al[0] = 0;
        al[1] = (lim > 0) ? lim - 1 : 0;
        al[2] = (lim > 65535) ? 65535 : lim;
        al[3] = 65535;
        for (int k = 0; k < 4; k++) begin
          bit ill;
          ill = (ext == 0) && (sz > 0) && (sz < 64) && (al[k] >= lim);
          ext_prog_en = ext[0];
          pmem_kb = 7'(sz);
          fetch_addr = 16'(al[k]);
          fetch_valid = 1'b1;
          edges(1);
          fetch_valid = 1'b0;
          chk("R7 R8 irq level", iaf_irq_n, ill ? 0 : 1);
          chk("R8 no reset", core_rst_n, 1);
          edges(1);
          chk("R8 irq pulse ends", iaf_irq_n, 1);
        end
      end
    end
    chk("R8 no cause bit", rst_cause, 0);

    // R9 direct mode
    iaf_direct = 1'b1; ext_prog_en = 1'b0; pmem_kb = 7'd8;
    fetch_addr = 16'h1fff; fetch_valid = 1'b1;
    edges(1);
    chk("R9 legal no reset", core_rst_n, 1);
    fetch_addr = 16'h2000;
    edges(1);
    fetch_valid = 1'b0;
    chk("R9 core asserted", core_rst_n, 0);
    chk("R9 no irq", iaf_irq_n, 1);
    chk("R9 cause bit", rst_cause, 6'b100000);
    edges(FAST - 1);
    chk("R9 core still low", core_rst_n, 0);
    edges(1);
    chk("R9 core released", core_rst_n, 1);

    // R1 R11 second power-on clears warm bits
    por_n = 1'b0;
    edges(1);
    chk("R1 cause after repower", rst_cause, 1);
    chk("R11 cold after repower", last_cold, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule